// File: doc/BRIEF.md
# Serial Flash Command Engine with Shared Byte FIFO

This block is a memory-mapped SPI master that runs one serial-flash command per request. Software loads a command opcode, a packed pair of byte counts, and the outgoing payload through a byte-wide register bus, then sets a start bit. The engine pulls chip select low, shifts out the opcode, then the payload bytes, then clocks in the requested number of response bytes. It then releases chip select.

The opcode has a register of its own. Outgoing and incoming data share one eight-entry byte FIFO, which is reached through a single data port. Each access to that port uses the byte under a software-visible pointer and then advances the pointer. Response bytes are stored directly behind the payload bytes. After a transfer, software clears the pointer, reads past the payload bytes and then collects the response. The serial link uses mode 0 (clock idle low, data sampled on the rising edge), most significant bit first. The serial clock is the system clock divided by a fixed parameter.

Top module: `sflash_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1 and spi_sck is 0, and the opcode, counts, control and pointer registers all read 0.
- R2: The opcode register sits at offset 0x00. The count register sits at offset 0x01, with the receive count in bits 7:4 and the transmit count in bits 3:0. Both read back what was last written while the engine was idle.
- R3: Each read or write at offset 0x0C accesses the FIFO byte at the pointer and then advances the pointer modulo 8. The pointer reads back in bits 2:0 of offset 0x0D.
- R4: Writing a control byte (offset 0x02) with bit 4 set returns the pointer to 0.
- R5: Writing a control byte with bit 0 set while idle starts a transfer. Control bit 0 reads 1 from the next cycle until the transfer ends. Bit 7 of offset 0x03 reads 1 while a byte is being shifted.
- R6: On MOSI the engine sends the opcode first, then FIFO bytes 0 to T-1 (T = transmit count), each MSB first in mode 0. SCK is low whenever no byte is being shifted.
- R7: With T greater than 0, R response bytes (R = receive count) are stored at FIFO positions T, T+1, … modulo 8, in the order they arrive.
- R8: With T equal to 0, only R-1 response bytes are taken (none when R is 0), and they are stored from position 0.
- R9: spi_cs_n stays low for the whole transfer. Exactly 8·(1+T+Reff) SCK pulses occur, where Reff is the number of response bytes taken.
- R10: While a transfer is active, writes to the opcode, the counts and the data port are ignored, and a data-port write then does not move the pointer.
- R11: Each SCK high phase lasts SCK_HALF system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Register offset within the 32-byte block |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address, combinational |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The assertions assume that each bus strobe lasts one cycle, that read and write strobes are never high together, and that SCK_HALF is at least 1. The FIFO assertion on exclusive write ports also relies on the engine gating bus writes while it is active. The stimulus issues every access as an isolated one-cycle strobe and never raises both strobes. Random transfers keep the transmit count within the FIFO depth and let the receive count cover its full range, so response storage wraps. Directed cases cover the zero-transmit slot discard, a zero-length read and writes made while the engine is busy.

// File: rtl/sfce_pkg.sv
package sfce_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam int IDX_W  = CNT_W + 1;

    localparam logic [4:0] OFS_OPCODE = 5'h00;
    localparam logic [4:0] OFS_COUNTS = 5'h01;
    localparam logic [4:0] OFS_CTRL   = 5'h02;
    localparam logic [4:0] OFS_STATUS = 5'h03;
    localparam logic [4:0] OFS_DATA   = 5'h0C;
    localparam logic [4:0] OFS_PTR    = 5'h0D;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_CLR_BIT = 4;
    localparam int STAT_BSY_BIT = 7;

    localparam logic [BYTE_W-1:0] RX_FILL = 8'h00;

    typedef struct packed {
        logic [CNT_W-1:0] rx;
        logic [CNT_W-1:0] tx;
    } counts_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    function automatic logic [CNT_W-1:0] rx_taken(input logic [CNT_W-1:0] tx,
                                                  input logic [CNT_W-1:0] rx);
        if (tx == '0 && rx != '0)
            return rx - 1'b1;
        else if (tx == '0)
            return '0;
        else
            return rx;
    endfunction

    function automatic logic [IDX_W-1:0] final_index(input logic [CNT_W-1:0] tx,
                                                     input logic [CNT_W-1:0] rx);
        return {1'b0, tx} + {1'b0, rx_taken(tx, rx)};
    endfunction

endpackage

// File: rtl/sfce_fifo.sv
module sfce_fifo
    import sfce_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [PTR_W-1:0]  ptr,
    input  logic [PTR_W-1:0]  eng_ridx,
    output logic [BYTE_W-1:0] eng_rdata,
    input  logic              eng_we,
    input  logic [PTR_W-1:0]  eng_widx,
    input  logic [BYTE_W-1:0] eng_wdata
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            ptr <= '0;
        end else begin
            if (eng_we) mem[eng_widx] <= eng_wdata;
            if (bus_we) mem[ptr] <= bus_wdata;
            if (clr)
                ptr <= '0;
            else if (bus_we || bus_re)
                ptr <= ptr + 1'b1;
        end
    end

    assign bus_rdata = mem[ptr];
    assign eng_rdata = mem[eng_ridx];

    assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (rst)
        clr |=> ptr == '0);

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
        ((bus_we || bus_re) && !clr) |=> ptr == $past(ptr) + 1'b1);

    assert_one_writer_R10: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && eng_we));

endmodule

// File: rtl/sfce_shifter.sv
module sfce_shifter
    import sfce_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] out_sr;
    logic [BYTE_W-1:0] in_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            sck    <= 1'b0;
            done   <= 1'b0;
            div_q  <= '0;
            bit_q  <= '0;
            out_sr <= '0;
            in_sr  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    out_sr <= tx_byte;
                    div_q  <= '0;
                    bit_q  <= '0;
                    sck    <= 1'b0;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (!sck) begin
                    sck   <= 1'b1;
                    in_sr <= {in_sr[BYTE_W-2:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_q == BIT_W'(BYTE_W - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_q  <= bit_q + 1'b1;
                        out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign mosi    = out_sr[BYTE_W-1];
    assign rx_byte = in_sr;

    assert_sck_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/sfce_seq.sv
module sfce_seq
    import sfce_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [BYTE_W-1:0] opcode,
    input  counts_t           counts,
    input  logic              sh_done,
    input  logic [BYTE_W-1:0] sh_rx,
    output logic              sh_start,
    output logic [BYTE_W-1:0] sh_tx,
    output logic [PTR_W-1:0]  fifo_ridx,
    input  logic [BYTE_W-1:0] fifo_rdata,
    output logic              fifo_we,
    output logic [PTR_W-1:0]  fifo_widx,
    output logic [BYTE_W-1:0] fifo_wdata,
    output logic              active
);

    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;
    logic [CNT_W-1:0] txn_q;
    logic [IDX_W-1:0] idx_next;
    logic [IDX_W-1:0] idx_prev;
    logic             in_rx_phase;

    assign idx_next    = idx_q + 1'b1;
    assign idx_prev    = idx_q - 1'b1;
    assign in_rx_phase = idx_q > {1'b0, txn_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            idx_q    <= '0;
            last_q   <= '0;
            txn_q    <= '0;
            sh_start <= 1'b0;
            sh_tx    <= '0;
        end else begin
            sh_start <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (go) begin
                        state_q  <= SQ_RUN;
                        idx_q    <= '0;
                        last_q   <= final_index(counts.tx, counts.rx);
                        txn_q    <= counts.tx;
                        sh_start <= 1'b1;
                        sh_tx    <= opcode;
                    end
                end
                SQ_RUN: begin
                    if (sh_done) begin
                        if (idx_q == last_q) begin
                            state_q <= SQ_IDLE;
                        end else begin
                            idx_q    <= idx_next;
                            sh_start <= 1'b1;
                            sh_tx    <= (idx_next <= {1'b0, txn_q}) ? fifo_rdata : RX_FILL;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign active     = (state_q == SQ_RUN);
    assign fifo_ridx  = idx_q[PTR_W-1:0];
    assign fifo_we    = active && sh_done && in_rx_phase;
    assign fifo_widx  = idx_prev[PTR_W-1:0];
    assign fifo_wdata = sh_rx;

    assert_go_starts_R5: assert property (@(posedge clk) disable iff (rst)
        (go && !active) |=> active);

    assert_done_in_run_R9: assert property (@(posedge clk) disable iff (rst)
        sh_done |-> active);

endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
    import sfce_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int SCK_HALF   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);

    localparam int PTR_W = $clog2(FIFO_DEPTH);

    logic [BYTE_W-1:0] opcode_q;
    counts_t           counts_q;
    logic              seq_active;
    logic              go, ptr_clr, fifo_bus_we, fifo_bus_re;
    logic [BYTE_W-1:0] fifo_bus_rdata, fifo_eng_rdata, fifo_eng_wdata;
    logic [PTR_W-1:0]  fifo_ptr, fifo_ridx, fifo_widx;
    logic              fifo_eng_we;
    logic              sh_start, sh_busy, sh_done;
    logic [BYTE_W-1:0] sh_tx, sh_rx;

    assign go          = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[CTRL_GO_BIT];
    assign ptr_clr     = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[CTRL_CLR_BIT];
    assign fifo_bus_we = bus_wr && (bus_addr == OFS_DATA) && !seq_active;
    assign fifo_bus_re = bus_rd && (bus_addr == OFS_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            opcode_q <= '0;
            counts_q <= '0;
        end else if (bus_wr && !seq_active) begin
            if (bus_addr == OFS_OPCODE) opcode_q <= bus_wdata;
            if (bus_addr == OFS_COUNTS) counts_q <= counts_t'(bus_wdata);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_OPCODE: bus_rdata = opcode_q;
            OFS_COUNTS: bus_rdata = counts_q;
            OFS_CTRL:   bus_rdata[CTRL_GO_BIT] = seq_active;
            OFS_STATUS: bus_rdata[STAT_BSY_BIT] = sh_busy;
            OFS_DATA:   bus_rdata = fifo_bus_rdata;
            OFS_PTR:    bus_rdata = {{(BYTE_W - PTR_W){1'b0}}, fifo_ptr};
            default:    bus_rdata = '0;
        endcase
    end

    sfce_fifo #(.DEPTH(FIFO_DEPTH), .PTR_W(PTR_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (ptr_clr),
        .bus_we    (fifo_bus_we),
        .bus_re    (fifo_bus_re),
        .bus_wdata (bus_wdata),
        .bus_rdata (fifo_bus_rdata),
        .ptr       (fifo_ptr),
        .eng_ridx  (fifo_ridx),
        .eng_rdata (fifo_eng_rdata),
        .eng_we    (fifo_eng_we),
        .eng_widx  (fifo_widx),
        .eng_wdata (fifo_eng_wdata)
    );

    sfce_seq #(.PTR_W(PTR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .opcode     (opcode_q),
        .counts     (counts_q),
        .sh_done    (sh_done),
        .sh_rx      (sh_rx),
        .sh_start   (sh_start),
        .sh_tx      (sh_tx),
        .fifo_ridx  (fifo_ridx),
        .fifo_rdata (fifo_eng_rdata),
        .fifo_we    (fifo_eng_we),
        .fifo_widx  (fifo_widx),
        .fifo_wdata (fifo_eng_wdata),
        .active     (seq_active)
    );

    sfce_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    assign spi_cs_n = !seq_active;

    assert_cs_covers_shift_R9: assert property (@(posedge clk) disable iff (rst)
        sh_busy |-> !spi_cs_n);

    assert_opcode_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (seq_active && bus_wr && bus_addr == OFS_OPCODE) |=> $stable(opcode_q));

    assert_counts_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (seq_active && bus_wr && bus_addr == OFS_COUNTS) |=> $stable(counts_q));

endmodule

// File: tb/sflash_cmd_engine_test.sv
module sflash_cmd_engine_test;

    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       spi_sck, spi_mosi, spi_miso, spi_cs_n;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sflash_cmd_engine #(.FIFO_DEPTH(8), .SCK_HALF(HALF)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // Flash model: records MOSI on rising SCK, presents MISO from resp[]
    int         bitpos = 0;
    int         pulses = 0;
    int         cs_viol = 0;
    logic [7:0] seen [32];
    logic [7:0] resp [32];

    always @(negedge spi_cs_n) begin
        bitpos = 0;
        pulses = 0;
    end
    always @(posedge spi_sck) begin
        if (spi_cs_n) cs_viol++;
        seen[(bitpos >> 3) & 31][7 - (bitpos & 7)] = spi_mosi;
        pulses++;
    end
    always @(negedge spi_sck) bitpos++;
    always_comb spi_miso = resp[(bitpos >> 3) & 31][7 - (bitpos & 7)];

    int hi_run = 0, hi_min = 1000, hi_max = 0, idle_sck = 0;
    always @(negedge clk) begin
        if (spi_sck) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (!rst && spi_cs_n && spi_sck) idle_sck++;
    end

    logic [7:0] model [8];
    logic [7:0] txbuf [8];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic int exp_rx(input int t, input int r);
        if (t == 0) return (r == 0) ? 0 : r - 1;
        return r;
    endfunction

    task automatic run_txn(input logic [7:0] op, input int t, input int r, input bit poke);
        logic [7:0] d;
        logic [7:0] ptr_before;
        int re;
        re = exp_rx(t, r);
        for (int i = 0; i < 32; i++) resp[i] = 8'($urandom);
        bwrite(5'h02, 8'h10);
        bread(5'h0D, d);
        check("R4 pointer clear", d, 0);
        bwrite(5'h00, op);
        bwrite(5'h01, 8'((r << 4) | t));
        for (int i = 0; i < t; i++) begin
            bwrite(5'h0C, txbuf[i]);
            model[i] = txbuf[i];
        end
        bwrite(5'h02, 8'h01);
        bread(5'h02, d);
        check("R5 go bit set", int'(d[0]), 1);
        bread(5'h03, d);
        check("R5 busy flag", int'(d[7]), 1);
        if (poke) begin
            bread(5'h0D, ptr_before);
            bwrite(5'h00, 8'hEE);
            bwrite(5'h01, 8'hFF);
            bwrite(5'h0C, 8'h5A);
            bread(5'h0D, d);
            check("R10 data write ignored, pointer", d, ptr_before);
        end
        for (int k = 0; k < 4000; k++) begin
            bread(5'h02, d);
            if (d[0] == 1'b0) break;
        end
        check("R5 go bit clears", int'(d[0]), 0);
        check("R1 cs_n idle high", int'(spi_cs_n), 1);
        check("R9 sck pulse count", pulses, 8 * (1 + t + re));
        check("R6 opcode on wire", seen[0], op);
        for (int i = 0; i < t; i++)
            check("R6 payload on wire", seen[1 + i], txbuf[i]);
        for (int k = 0; k < re; k++)
            model[(t + k) % 8] = resp[1 + t + k];
        if (poke) begin
            bread(5'h00, d);
            check("R10 opcode write ignored", d, op);
            bread(5'h01, d);
            check("R10 counts write ignored", d, 8'((r << 4) | t));
        end
        bwrite(5'h02, 8'h10);
        for (int i = 0; i < 8; i++) begin
            bread(5'h0C, d);
            if (t == 0) check("R8 fifo after transfer", d, model[i]);
            else        check("R7 fifo after transfer", d, model[i]);
        end
        bread(5'h0D, d);
        check("R3 pointer wraps to 0", d, 0);
    endtask

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        for (int i = 0; i < 32; i++) begin
            resp[i] = 8'h00;
            seen[i] = 8'h00;
        end
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 cs_n after reset", int'(spi_cs_n), 1);
        check("R1 sck after reset", int'(spi_sck), 0);
        bread(5'h00, d); check("R1 opcode reset", d, 0);
        bread(5'h01, d); check("R1 counts reset", d, 0);
        bread(5'h02, d); check("R1 control reset", d, 0);
        bread(5'h0D, d); check("R1 pointer reset", d, 0);

        // R2 register readback
        bwrite(5'h00, 8'h9F);
        bread(5'h00, d); check("R2 opcode readback", d, 8'h9F);
        bwrite(5'h01, 8'h35);
        bread(5'h01, d); check("R2 counts readback", d, 8'h35);

        // R3 data port advance and wrap
        bwrite(5'h02, 8'h10);
        for (int i = 0; i < 10; i++) begin
            bwrite(5'h0C, 8'(8'h30 + i));
            model[i % 8] = 8'(8'h30 + i);
        end
        bread(5'h0D, d); check("R3 pointer after 10 writes", d, 2);
        bread(5'h0C, d); check("R3 read at pointer 2", d, model[2]);
        bread(5'h0D, d); check("R3 pointer after read", d, 3);
        bwrite(5'h02, 8'h10);
        bread(5'h0C, d); check("R3 wrapped byte at 0", d, 8'h38);

        // directed corner cases
        for (int i = 0; i < 8; i++) txbuf[i] = 8'(8'hA0 + i);
        run_txn(8'h05, 0, 0, 1'b0);   // R8 zero-length read
        run_txn(8'h9F, 0, 4, 1'b0);   // R8 slot discard
        run_txn(8'h02, 8, 0, 1'b0);   // R6 full payload
        run_txn(8'h0B, 3, 15, 1'b0);  // R7 wraps
        run_txn(8'h03, 2, 6, 1'b1);   // R10 writes while busy

        // random transfers
        for (int n = 0; n < 16; n++) begin
            for (int i = 0; i < 8; i++) txbuf[i] = 8'($urandom);
            run_txn(8'($urandom), int'($urandom_range(0, 8)), int'($urandom_range(0, 15)), 1'b0);
        end

        check("R9 no SCK edge with cs_n high", cs_viol, 0);
        check("R6 SCK low when deselected", idle_sck, 0);
        check("R11 shortest SCK high phase", hi_min, HALF);
        check("R11 longest SCK high phase", hi_max, HALF);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule